// File: doc/BRIEF.md
# Read strobe preamble generator

This block is the memory-side source of the differential read data strobe in a DDR4-style device model. It takes decoded commands (a mode register write that carries the preamble-length bit and the training bit, a normal read and an MPR page-0 read), an MPR-access-mode level and a CAS latency value. It drives the strobe pair, a strobe output enable and a control that parks the data lines high. A read produces a one- or two-clock low preamble, a burst of eight strobe edges (four clocks, rising edge in the first half of each clock), a half-clock low postamble, and then the output enable is released.

Each output is a 2-bit vector per clock: bit 1 is the first half of the clock and bit 0 is the second half. A training mode, entered only while the device is in MPR access mode, first waits a settle interval of `TSDO` clocks. It then parks the strobe (true low, complement high, enable on) with the data lines held high. Only an MPR read leaves this parked level, and the block returns to it after the postamble. Training ends only when a mode register write clears the training bit.

The controller has the states IDLE, SETTLE, PARK, WAIT, PRE, BURST and POST. IDLE goes to SETTLE on an accepted training enable and to WAIT on a read. SETTLE goes to PARK when its counter runs out, and to IDLE when training is cleared. PARK goes to WAIT on an MPR read and to IDLE when training is cleared. WAIT goes to PRE after the latency countdown, PRE goes to BURST after one or two clocks, and BURST goes to POST after four clocks. POST goes to WAIT if a read is held or arrives, to PARK if training is active, and to IDLE otherwise.

Top module: `rd_strobe_gen`

## Requirements
- R1: After reset the outputs are idle: enable 2'b00, true strobe 2'b00, complement 2'b11, data park 0, training off.
- R2: With the preamble bit 0, a read sampled at edge E0 gives, counting k clocks after E0: a preamble (enable 11, true 00) at k=CL-1, burst clocks (enable 11, true 2'b10) at k=CL to CL+3, a postamble (enable 2'b10, true 00) at k=CL+4, and rest levels from k=CL+5.
- R3: With the preamble bit 1, the preamble covers k=CL-2 and k=CL-1, and burst and postamble timing is unchanged.
- R4: CAS latency is sampled when a read launches and is clamped to the range 9 to 24.
- R5: The complement strobe is always the bitwise inverse of the true strobe.
- R6: A mode register write always updates the preamble bit. A training enable takes effect only if MPR mode is 1 and the block is idle (not training, no read in progress); otherwise it is ignored.
- R7: After an accepted training enable at edge E, clocks k=0 to TSDO-1 show enable 00 with data park 1, and from k=TSDO the strobe is parked: enable 11, true 00, complement 11, data park 1.
- R8: While training, only an MPR read starts a burst. Normal reads, and any read during the settle interval, are ignored. During the preamble and postamble of a training read, data park stays 1; during the burst it is 0. After the postamble the parked levels return.
- R9: Training persists when MPR mode drops and ends only on a mode register write with the training bit 0; the rest levels are idle from the next clock.
- R10: One read arriving while a read is in progress is held and launches at the edge that ends the postamble, timed as if issued there. A further read that arrives while one is held is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_mrs | input | 1 | Mode register write strobe |
| mrs_pre2 | input | 1 | Preamble length bit carried by the write (1 = two clocks) |
| mrs_train | input | 1 | Training enable bit carried by the write |
| mpr_mode | input | 1 | Device is in MPR access mode |
| cmd_rd | input | 1 | Normal read command |
| cmd_mpr_rd | input | 1 | MPR page-0 read command |
| cas_lat | input | CL_W | CAS latency in clocks |
| dqs_t | output | 2 | True strobe, {first half, second half} |
| dqs_c | output | 2 | Complement strobe, {first half, second half} |
| dqs_oe | output | 2 | Strobe output enable, {first half, second half} |
| dq_park | output | 1 | Hold data lines high |

## Verification
The embedded assertions check on every clock that the two strobes are complementary and that a postamble only ever follows a burst. They also check that the latency countdown loads a value inside the clamped range, that a training enable outside MPR mode leaves training off, that training is never lost without a clearing write, that the parked state implies training, and that nothing is held while idle. The exact clock of each preamble, burst and postamble edge can only be shown by the bench scenarios, which compare every output against a behavioural schedule. The same applies to the length of the settle interval, the launch of a held read at the postamble boundary, and the dropping of reads that are ignored.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_PARK   = 3'd2,
        ST_WAIT   = 3'd3,
        ST_PRE    = 3'd4,
        ST_BURST  = 3'd5,
        ST_POST   = 3'd6
    } rsg_state_e;

    function automatic int unsigned clamp_lat(input int unsigned v,
                                              input int unsigned lo,
                                              input int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/rsg_ctrl.sv
module rsg_ctrl
    import rsg_pkg::*;
#(
    parameter int unsigned TSDO      = 8,
    parameter int unsigned CL_W      = 5,
    parameter int unsigned CL_MIN    = 9,
    parameter int unsigned CL_MAX    = 24,
    parameter int unsigned BURST_CYC = 4,
    parameter int unsigned CNT_W     = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_mrs,
    input  logic            mrs_pre2,
    input  logic            mrs_train,
    input  logic            mpr_mode,
    input  logic            cmd_rd,
    input  logic            cmd_mpr_rd,
    input  logic [CL_W-1:0] cas_lat,
    output rsg_state_e      state_o,
    output logic            train_o
);

    rsg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, launch_cnt;
    logic             train_q, train_d;
    logic             pre2_q, pre2_d;
    logic             lp2_q, lp2_d;
    logic             pend_q, pend_d;
    logic             acc, en_ok, dis, go;

    always_comb begin
        acc   = (train_q ? cmd_mpr_rd : (cmd_rd | cmd_mpr_rd)) && (state_q != ST_SETTLE);
        en_ok = cmd_mrs && mrs_train && mpr_mode && (state_q == ST_IDLE);
        dis   = cmd_mrs && !mrs_train;
        launch_cnt = CNT_W'(clamp_lat(32'(cas_lat), CL_MIN, CL_MAX)
                            - (pre2_q ? 32'd2 : 32'd1) - 32'd1);
        pre2_d  = cmd_mrs ? mrs_pre2 : pre2_q;
        train_d = en_ok ? 1'b1 : (dis ? 1'b0 : train_q);
        state_d = state_q;
        cnt_d   = cnt_q;
        lp2_d   = lp2_q;
        pend_d  = pend_q;
        go      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en_ok) begin
                    state_d = ST_SETTLE;
                    cnt_d   = CNT_W'(TSDO - 1);
                end else if (acc) begin
                    go = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (dis)                state_d = ST_IDLE;
                else if (cnt_q == '0)   state_d = ST_PARK;
                else                    cnt_d   = cnt_q - CNT_W'(1);
            end
            ST_PARK: begin
                if (acc)      go      = 1'b1;
                else if (dis) state_d = ST_IDLE;
            end
            ST_WAIT: begin
                pend_d = pend_q | acc;
                if (cnt_q == '0) begin
                    state_d = ST_PRE;
                    cnt_d   = lp2_q ? CNT_W'(1) : '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_PRE: begin
                pend_d = pend_q | acc;
                if (cnt_q == '0) begin
                    state_d = ST_BURST;
                    cnt_d   = CNT_W'(BURST_CYC - 1);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_BURST: begin
                pend_d = pend_q | acc;
                if (cnt_q == '0) state_d = ST_POST;
                else             cnt_d   = cnt_q - CNT_W'(1);
            end
            ST_POST: begin
                if (pend_q || acc) begin
                    go     = 1'b1;
                    pend_d = pend_q && acc;
                end else begin
                    state_d = train_d ? ST_PARK : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (go) begin
            state_d = ST_WAIT;
            cnt_d   = launch_cnt;
            lp2_d   = pre2_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            train_q <= 1'b0;
            pre2_q  <= 1'b0;
            lp2_q   <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            train_q <= train_d;
            pre2_q  <= pre2_d;
            lp2_q   <= lp2_d;
            pend_q  <= pend_d;
        end
    end

    assign state_o = state_q;
    assign train_o = train_q;

    // R10
    no_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !pend_q);
    // R6
    trn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_mrs && mrs_train && !mpr_mode && !train_q) |=> !train_q);
    // R7
    park_trn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK) |-> train_q);
    // R2
    post_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POST) |-> ($past(state_q) == ST_BURST));
    // R9
    trn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (train_q && !(cmd_mrs && !mrs_train)) |=> train_q);
    // R4
    lat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && $past(state_q) != ST_WAIT)
        |-> (cnt_q >= CNT_W'(CL_MIN - 3) && cnt_q <= CNT_W'(CL_MAX - 2)));

endmodule

// File: rtl/rsg_drive.sv
module rsg_drive
    import rsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rsg_state_e state_i,
    input  logic       train_i,
    output logic [1:0] dqs_t,
    output logic [1:0] dqs_c,
    output logic [1:0] dqs_oe,
    output logic       dq_park
);

    always_comb begin
        dqs_t   = 2'b00;
        dqs_c   = 2'b11;
        dqs_oe  = 2'b00;
        dq_park = 1'b0;
        unique case (state_i)
            ST_IDLE: ;
            ST_SETTLE: dq_park = 1'b1;
            ST_PARK: begin
                dqs_oe  = 2'b11;
                dq_park = 1'b1;
            end
            ST_WAIT: begin
                dqs_oe  = train_i ? 2'b11 : 2'b00;
                dq_park = train_i;
            end
            ST_PRE: begin
                dqs_oe  = 2'b11;
                dq_park = train_i;
            end
            ST_BURST: begin
                dqs_t  = 2'b10;
                dqs_c  = 2'b01;
                dqs_oe = 2'b11;
            end
            ST_POST: begin
                dqs_oe  = 2'b10;
                dq_park = train_i;
            end
            default: ;
        endcase
    end

    // R5
    strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_c == ~dqs_t);

endmodule

// File: rtl/rd_strobe_gen.sv
module rd_strobe_gen
    import rsg_pkg::*;
#(
    parameter int unsigned TSDO   = 8,
    parameter int unsigned CL_W   = 5,
    parameter int unsigned CL_MIN = 9,
    parameter int unsigned CL_MAX = 24,
    parameter int unsigned BEATS  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_mrs,
    input  logic            mrs_pre2,
    input  logic            mrs_train,
    input  logic            mpr_mode,
    input  logic            cmd_rd,
    input  logic            cmd_mpr_rd,
    input  logic [CL_W-1:0] cas_lat,
    output logic [1:0]      dqs_t,
    output logic [1:0]      dqs_c,
    output logic [1:0]      dqs_oe,
    output logic            dq_park
);

    localparam int unsigned BURST_CYC = BEATS / 2;
    localparam int unsigned LAT_SPAN  = 1 << CL_W;
    localparam int unsigned CNT_MAX   = (TSDO > LAT_SPAN) ? TSDO : LAT_SPAN;
    localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

    rsg_state_e state;
    logic       train;

    rsg_ctrl #(
        .TSDO(TSDO), .CL_W(CL_W), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX),
        .BURST_CYC(BURST_CYC), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_mrs(cmd_mrs), .mrs_pre2(mrs_pre2),
        .mrs_train(mrs_train), .mpr_mode(mpr_mode), .cmd_rd(cmd_rd),
        .cmd_mpr_rd(cmd_mpr_rd), .cas_lat(cas_lat),
        .state_o(state), .train_o(train)
    );

    rsg_drive u_drive (
        .clk(clk), .rst_n(rst_n), .state_i(state), .train_i(train),
        .dqs_t(dqs_t), .dqs_c(dqs_c), .dqs_oe(dqs_oe), .dq_park(dq_park)
    );

endmodule

// File: tb/rd_strobe_gen_tb.sv
module rd_strobe_gen_tb;

    localparam int TSDO = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_mrs = 0, mrs_pre2 = 0, mrs_train = 0, mpr_mode = 0;
    logic       cmd_rd = 0, cmd_mpr_rd = 0;
    logic [4:0] cas_lat = 5'd11;
    logic [1:0] dqs_t, dqs_c, dqs_oe;
    logic       dq_park;

    int    checks = 0, fails = 0, cyc = 0;
    bit    started = 0, done = 0;
    string cur_req = "R1";
    logic [6:0] exp_v = 7'b00_00_11_0;

    // behavioural model state
    bit m_act = 0, m_pend = 0, m_train = 0, m_pre2 = 0;
    int m_t0 = 0, m_lat = 0, m_pp = 1, m_sete = 0;

    always #4 clk = ~clk;

    rd_strobe_gen #(.TSDO(TSDO)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_mrs(cmd_mrs), .mrs_pre2(mrs_pre2),
        .mrs_train(mrs_train), .mpr_mode(mpr_mode), .cmd_rd(cmd_rd),
        .cmd_mpr_rd(cmd_mpr_rd), .cas_lat(cas_lat),
        .dqs_t(dqs_t), .dqs_c(dqs_c), .dqs_oe(dqs_oe), .dq_park(dq_park)
    );

    function automatic int clampv(input int v);
        if (v < 9) return 9;
        if (v > 24) return 24;
        return v;
    endfunction

    always @(posedge clk) begin
        int  n, k;
        bit  busy, in_post, in_settle, acc, en, dis, go;
        if (!rst_n) begin
            m_act = 0; m_pend = 0; m_train = 0; m_pre2 = 0; cyc = 0;
            exp_v = 7'b00_00_11_0;
        end else begin
            started = 1;
            n = cyc + 1;
            cyc = n;
            busy      = m_act && ((n - 1 - m_t0) <= m_lat + 4);
            in_post   = m_act && ((n - 1 - m_t0) == m_lat + 4);
            in_settle = m_train && ((n - 1) < m_sete);
            acc = (m_train ? cmd_mpr_rd : (cmd_rd | cmd_mpr_rd)) && !in_settle;
            en  = cmd_mrs && mrs_train && mpr_mode && !busy && !m_train;
            dis = cmd_mrs && !mrs_train;
            go  = 0;
            if (busy) begin
                if (in_post) begin
                    if (m_pend || acc) begin
                        go = 1;
                        m_pend = m_pend && acc;
                    end
                end else begin
                    m_pend = m_pend || acc;
                end
            end else if (!en && acc) begin
                go = 1;
            end
            if (go) begin
                m_act = 1; m_t0 = n; m_lat = clampv(int'(cas_lat));
                m_pp = m_pre2 ? 2 : 1;
            end
            if (cmd_mrs) m_pre2 = mrs_pre2;
            if (en) begin
                m_train = 1; m_sete = n + TSDO;
            end else if (dis) begin
                m_train = 0;
            end
            k = n - m_t0;
            if (m_act && k <= m_lat + 4 && k >= m_lat - m_pp) begin
                if (k < m_lat)          exp_v = {2'b11, 2'b00, 2'b11, m_train};
                else if (k < m_lat + 4) exp_v = {2'b11, 2'b10, 2'b01, 1'b0};
                else                    exp_v = {2'b10, 2'b00, 2'b11, m_train};
            end else if (m_train) begin
                exp_v = (n < m_sete) ? 7'b00_00_11_1 : 7'b11_00_11_1;
            end else begin
                exp_v = 7'b00_00_11_0;
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if ({dqs_oe, dqs_t, dqs_c, dq_park} !== exp_v) begin
                fails++;
                $display("FAIL %s cycle %0d: actual %b expected %b",
                         cur_req, cyc, {dqs_oe, dqs_t, dqs_c, dq_park}, exp_v);
            end
        end
    end

    task automatic pulse(input bit rd, input bit mrd, input bit mrs,
                         input bit p2, input bit trn);
        cmd_rd = rd; cmd_mpr_rd = mrd; cmd_mrs = mrs; mrs_pre2 = p2; mrs_train = trn;
        @(negedge clk);
        cmd_rd = 0; cmd_mpr_rd = 0; cmd_mrs = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        checks++;
        if ({dqs_oe, dqs_t, dqs_c, dq_park} !== 7'b00_00_11_0) begin
            fails++;
            $display("FAIL R1 reset: actual %b expected %b",
                     {dqs_oe, dqs_t, dqs_c, dq_park}, 7'b00_00_11_0);
        end
        rst_n = 1;
        idle(4);

        cur_req = "R2";
        cas_lat = 5'd11;
        pulse(1, 0, 0, 0, 0);
        idle(20);

        cur_req = "R3";
        pulse(0, 0, 1, 1, 0);
        idle(2);
        cas_lat = 5'd9;
        pulse(1, 0, 0, 0, 0);
        idle(18);
        cas_lat = 5'd13;
        pulse(0, 1, 0, 0, 0);
        idle(22);

        cur_req = "R4";
        cas_lat = 5'd3;
        pulse(1, 0, 0, 0, 0);
        cas_lat = 5'd20;
        idle(20);
        cas_lat = 5'd30;
        pulse(1, 0, 0, 0, 0);
        idle(34);
        cas_lat = 5'd24;
        pulse(1, 0, 0, 0, 0);
        idle(34);

        cur_req = "R10";
        pulse(0, 0, 1, 0, 0);
        cas_lat = 5'd9;
        pulse(1, 0, 0, 0, 0);
        idle(2);
        pulse(1, 0, 0, 0, 0);
        idle(1);
        pulse(1, 0, 0, 0, 0);
        idle(40);
        pulse(1, 0, 0, 0, 0);
        idle(9 + 4);
        pulse(1, 0, 0, 0, 0);
        idle(40);

        cur_req = "R6";
        mpr_mode = 0;
        pulse(0, 0, 1, 0, 1);
        idle(TSDO + 4);
        mpr_mode = 1;
        pulse(1, 0, 0, 0, 0);
        idle(3);
        pulse(0, 0, 1, 0, 1);
        idle(30);

        cur_req = "R7";
        pulse(0, 0, 1, 0, 1);
        idle(TSDO + 4);

        cur_req = "R8";
        pulse(1, 0, 0, 0, 0);
        idle(20);
        pulse(0, 1, 0, 0, 0);
        idle(22);
        pulse(0, 0, 1, 0, 0);
        idle(3);
        pulse(0, 0, 1, 1, 1);
        idle(2);
        pulse(0, 1, 0, 0, 0);
        idle(TSDO + 4);
        pulse(0, 1, 0, 0, 0);
        idle(22);

        cur_req = "R9";
        mpr_mode = 0;
        idle(6);
        pulse(0, 0, 1, 0, 1);
        idle(4);
        pulse(0, 0, 1, 0, 0);
        idle(6);
        pulse(1, 0, 0, 0, 0);
        idle(24);

        finish_run();
    end

endmodule